// File: doc/BRIEF.md
# Stack-Distance Miss and Writeback Profiler

This block watches one core's stream of last-level-cache accesses through a shadow tag directory and predicts how that core would behave under every possible way allocation at once. It keeps a small subset of the cache sets, one in every 32. For each kept set it holds a true-LRU stack of hashed partial tags whose depth equals the largest share any single core may be given. A hit at stack distance d means the access would also hit in any allocation of more than d ways.

Each stack entry also carries a dirty flag and the deepest distance at which the line has been touched while dirty. When a dirty line finally drops off the bottom of the stack, a single writeback is recorded at that deepest distance. A store therefore counts as one writeback in exactly those allocations too small to have held the line across its reuse. A management layer programs a way count W and reads back the predicted miss and writeback totals for W. A clear pulse starts a new measurement epoch.

Top module: `sdp_profiler`

## Requirements
- R1: After reset both prediction outputs are zero and every monitored stack is empty, so the first access to any monitored set is a miss.
- R2: The set index is address bits [12:6]. Only sets whose index bits [10:6] are all zero are monitored, and index bits [12:11] select one of four stacks. Accesses to any other set, or with the valid input low, change no count.
- R3: The stored tag is an 11-bit hash of address bits [31:13]: tag bit i is XORed into hash bit (i mod 11). Two tags with the same hash are the same line.
- R4: A hit at distance d from the MRU position (0 = MRU) adds one to the hit count of distance d. The line then moves to MRU, and the lines above it move down one place.
- R5: The predicted miss count for W ways equals the number of misses plus the number of hits at distances W and above.
- R6: A stack holds 9 lines. A miss puts the new line at MRU and drops the line at distance 8, so a tenth distinct line pushes out the oldest one.
- R7: A store sets the line's dirty flag. While a line is dirty, each hit raises its recorded distance to the larger of the old value and the hit distance. A store miss records distance 0.
- R8: When a dirty line is dropped, exactly one writeback is counted at its recorded distance. The predicted writeback count for W ways is the number of writebacks recorded at distances W and above.
- R9: Both predictions are registered. A change of the way-count input shows on the outputs one clock later. A way count above 9 counts no hits as misses.
- R10: A clear pulse zeroes all counts, so the outputs read zero two clocks later. The stack contents are kept, so a line seen before the clear can still hit.
- R11: Counters and prediction sums saturate at the all-ones value of the counter width and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Epoch clear: zeroes all counts |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_store | input | 1 | The access is a store |
| q_ways | input | QW_W | Way count W to predict for |
| pred_miss | output | CNT_W | Predicted misses for W ways |
| pred_wb | output | CNT_W | Predicted writebacks for W ways |

## Verification
Some wrong internal states never reach the outputs quickly. A stack entry in the wrong order, a dirty flag that was lost, or a recorded distance that is off by one stays hidden until that line is hit again or drops off the stack. That can take up to nine further misses in the same set. The reference model is therefore compared on every clock, with the way count swept so that each distance bucket is read on its own. Faults in the counters or the query sum show two clocks after the access that caused them.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int HTAG_W = 11;

  // XOR-fold an up-to-64-bit tag into HTAG_W bits
  function automatic logic [HTAG_W-1:0] fold_tag(input logic [63:0] t);
    logic [HTAG_W-1:0] h;
    h = '0;
    for (int b = 0; b < 64; b += HTAG_W) h ^= HTAG_W'(t >> b);
    return h;
  endfunction

  // saturating add, result clamped to lim
  function automatic logic [63:0] sat_add(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] lim);
    logic [64:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, lim}) ? lim : s[63:0];
  endfunction
endpackage

// File: rtl/sdp_addr_decode.sv
module sdp_addr_decode
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 7,
  parameter int SKIP_W = 5,
  localparam int SLOT_W  = SET_W - SKIP_W,
  localparam int TAG_LSB = OFF_W + SET_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sampled,
  output logic [SLOT_W-1:0] slot,
  output logic [HTAG_W-1:0] htag
);
  assign sampled = (addr[OFF_W +: SKIP_W] == '0);
  assign slot    = addr[OFF_W+SKIP_W +: SLOT_W];
  assign htag    = fold_tag(64'(addr[ADDR_W-1:TAG_LSB]));
endmodule

// File: rtl/sdp_lru_stack.sv
module sdp_lru_stack
  import sdp_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2,
  parameter int DEPTH  = 9,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [SLOT_W-1:0] slot,
  input  logic [HTAG_W-1:0] tag,
  input  logic              store,
  output logic              hit,
  output logic [POS_W-1:0]  hit_pos,
  output logic              victim_dirty,
  output logic [POS_W-1:0]  victim_pos
);
  logic [HTAG_W-1:0] tg_q [NSLOT][DEPTH];
  logic              vl_q [NSLOT][DEPTH];
  logic              dy_q [NSLOT][DEPTH];
  logic [POS_W-1:0]  dd_q [NSLOT][DEPTH];

  logic              head_d;
  logic [POS_W-1:0]  head_dd;

  // lowest matching position wins
  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vl_q[slot][i] && tg_q[slot][i] == tag) begin
        hit     = 1'b1;
        hit_pos = POS_W'(i);
      end
    end
  end

  assign victim_dirty = vl_q[slot][DEPTH-1] && dy_q[slot][DEPTH-1];
  assign victim_pos   = dd_q[slot][DEPTH-1];

  always_comb begin
    head_d  = store || (hit && dy_q[slot][hit_pos]);
    head_dd = '0;
    if (hit && head_d)
      head_dd = (dd_q[slot][hit_pos] > hit_pos) ? dd_q[slot][hit_pos] : hit_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        for (int i = 0; i < DEPTH; i++) begin
          tg_q[s][i] <= '0;
          vl_q[s][i] <= 1'b0;
          dy_q[s][i] <= 1'b0;
          dd_q[s][i] <= '0;
        end
      end
    end else if (upd) begin
      tg_q[slot][0] <= tag;
      vl_q[slot][0] <= 1'b1;
      dy_q[slot][0] <= head_d;
      dd_q[slot][0] <= head_dd;
      for (int i = 1; i < DEPTH; i++) begin
        if (!hit || i <= int'(hit_pos)) begin
          tg_q[slot][i] <= tg_q[slot][i-1];
          vl_q[slot][i] <= vl_q[slot][i-1];
          dy_q[slot][i] <= dy_q[slot][i-1];
          dd_q[slot][i] <= dd_q[slot][i-1];
        end
      end
    end
  end
endmodule

// File: rtl/sdp_counter_bank.sv
module sdp_counter_bank
  import sdp_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int POS_W = 4,
  parameter int QW_W  = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_miss,
  input  logic             ev_hit,
  input  logic [POS_W-1:0] hit_pos,
  input  logic             ev_wb,
  input  logic [POS_W-1:0] wb_pos,
  input  logic [QW_W-1:0]  q_ways,
  output logic [CNT_W-1:0] pred_miss,
  output logic [CNT_W-1:0] pred_wb
);
  localparam logic [63:0] LIM = 64'((65'd1 << CNT_W) - 65'd1);

  logic [CNT_W-1:0] miss_q;
  logic [CNT_W-1:0] hit_q [DEPTH];
  logic [CNT_W-1:0] wb_q  [DEPTH];
  logic [63:0]      tail_hits, tail_wbs, miss_sum;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] x);
    return CNT_W'(sat_add(64'(x), 64'd1, LIM));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        hit_q[i] <= '0;
        wb_q[i]  <= '0;
      end
    end else if (clr) begin
      miss_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        hit_q[i] <= '0;
        wb_q[i]  <= '0;
      end
    end else begin
      if (ev_miss) miss_q <= bump(miss_q);
      for (int i = 0; i < DEPTH; i++) begin
        if (ev_hit && int'(hit_pos) == i) hit_q[i] <= bump(hit_q[i]);
        if (ev_wb && int'(wb_pos) == i)   wb_q[i]  <= bump(wb_q[i]);
      end
    end
  end

  // sums over distances W and above
  always_comb begin
    tail_hits = '0;
    tail_wbs  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i >= int'(q_ways)) begin
        tail_hits = sat_add(tail_hits, 64'(hit_q[i]), LIM);
        tail_wbs  = sat_add(tail_wbs, 64'(wb_q[i]), LIM);
      end
    end
    miss_sum = sat_add(64'(miss_q), tail_hits, LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_miss <= '0;
      pred_wb   <= '0;
    end else begin
      pred_miss <= CNT_W'(miss_sum);
      pred_wb   <= CNT_W'(tail_wbs);
    end
  end
endmodule

// File: rtl/sdp_profiler.sv
module sdp_profiler
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 7,
  parameter int SKIP_W = 5,
  parameter int DEPTH  = 9,
  parameter int CNT_W  = 32,
  localparam int SLOT_W = SET_W - SKIP_W,
  localparam int NSLOT  = 1 << SLOT_W,
  localparam int POS_W  = $clog2(DEPTH),
  localparam int QW_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic [QW_W-1:0]   q_ways,
  output logic [CNT_W-1:0]  pred_miss,
  output logic [CNT_W-1:0]  pred_wb
);
  logic              acc_sampled;
  logic [SLOT_W-1:0] acc_slot;
  logic [HTAG_W-1:0] acc_htag;
  logic              lk_hit;
  logic [POS_W-1:0]  hit_pos;
  logic              vic_dirty;
  logic [POS_W-1:0]  wb_pos;

  // named internal events
  logic ev_upd, ev_hit, ev_miss, ev_wb;

  sdp_addr_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .SKIP_W(SKIP_W)
  ) i_decode (
    .addr(acc_addr), .sampled(acc_sampled), .slot(acc_slot), .htag(acc_htag)
  );

  assign ev_upd  = acc_valid && acc_sampled;
  assign ev_hit  = ev_upd && lk_hit;
  assign ev_miss = ev_upd && !lk_hit;
  assign ev_wb   = ev_miss && vic_dirty;

  sdp_lru_stack #(
    .NSLOT(NSLOT), .SLOT_W(SLOT_W), .DEPTH(DEPTH), .POS_W(POS_W)
  ) i_stack (
    .clk(clk), .rst_n(rst_n), .upd(ev_upd), .slot(acc_slot), .tag(acc_htag),
    .store(acc_store), .hit(lk_hit), .hit_pos(hit_pos),
    .victim_dirty(vic_dirty), .victim_pos(wb_pos)
  );

  sdp_counter_bank #(
    .DEPTH(DEPTH), .POS_W(POS_W), .QW_W(QW_W), .CNT_W(CNT_W)
  ) i_counts (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_miss(ev_miss), .ev_hit(ev_hit),
    .hit_pos(hit_pos), .ev_wb(ev_wb), .wb_pos(wb_pos), .q_ways(q_ways),
    .pred_miss(pred_miss), .pred_wb(pred_wb)
  );
endmodule

// File: rtl/sdp_profiler_chk.sv
module sdp_profiler_chk #(
  parameter int DEPTH = 9,
  parameter int POS_W = 4,
  parameter int QW_W  = 4,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             acc_valid,
  input logic             acc_sampled,
  input logic [QW_W-1:0]  q_ways,
  input logic             ev_upd,
  input logic             ev_hit,
  input logic             ev_miss,
  input logic             ev_wb,
  input logic [POS_W-1:0] hit_pos,
  input logic [POS_W-1:0] wb_pos,
  input logic [CNT_W-1:0] pred_miss,
  input logic [CNT_W-1:0] pred_wb
);
  // R2
  only_sampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit || ev_miss) |-> (acc_valid && acc_sampled));

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd |-> ($countones({ev_hit, ev_miss}) == 1));

  // R6
  hit_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> (int'(hit_pos) < DEPTH));

  // R8
  wb_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb |-> (ev_miss && int'(wb_pos) < DEPTH));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ##1 (pred_miss == '0 && pred_wb == '0));

  // R11
  no_wrap_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && !clr && $stable(q_ways)) |=> (pred_miss >= $past(pred_miss)));

  // R11
  no_wrap_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && !clr && $stable(q_ways)) |=> (pred_wb >= $past(pred_wb)));
endmodule

bind sdp_profiler sdp_profiler_chk #(
  .DEPTH(DEPTH), .POS_W(POS_W), .QW_W(QW_W), .CNT_W(CNT_W)
) i_sdp_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid),
  .acc_sampled(acc_sampled), .q_ways(q_ways), .ev_upd(ev_upd),
  .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_wb(ev_wb), .hit_pos(hit_pos),
  .wb_pos(wb_pos), .pred_miss(pred_miss), .pred_wb(pred_wb)
);

// File: tb/test_sdp_profiler.sv
`timescale 1ns/1ps
module test_sdp_profiler;
  localparam int DEPTH = 9;
  localparam int CW    = 8;
  localparam longint LIM = 255;

  logic        clk = 1'b0;
  logic        rst_n, clr, acc_valid, acc_store;
  logic [31:0] acc_addr;
  logic [3:0]  q_ways;
  logic [CW-1:0] pred_miss, pred_wb;

  always #10 clk = ~clk;

  sdp_profiler #(.CNT_W(CW)) i_sdp_profiler (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_store(acc_store), .q_ways(q_ways),
    .pred_miss(pred_miss), .pred_wb(pred_wb)
  );

  typedef struct {
    int unsigned tg;
    bit          d;
    int          dd;
  } ent_t;

  ent_t   stk [4][$];
  longint m_miss;
  longint m_hit [DEPTH];
  longint m_wb  [DEPTH];
  longint exp_miss, exp_wb;
  int     checks, fails;
  string  phase;
  bit     done;

  function automatic int unsigned hfold(input int unsigned t);
    int unsigned h = 0;
    for (int b = 0; b < 19; b++) if (t[b]) h ^= (32'd1 << (b % 11));
    return h;
  endfunction

  function automatic longint sat(input longint v);
    return (v > LIM) ? LIM : v;
  endfunction

  function automatic logic [31:0] mk(input int slot, input int unsigned tag);
    return {tag[18:0], 2'(slot), 5'd0, 6'd0};
  endfunction

  task automatic model_access(input int s, input int unsigned t, input bit st);
    int   idx = -1;
    ent_t e;
    for (int i = 0; i < stk[s].size(); i++)
      if (idx < 0 && stk[s][i].tg == t) idx = i;
    if (idx >= 0) begin
      m_hit[idx] = sat(m_hit[idx] + 1);
      e = stk[s][idx];
      stk[s].delete(idx);
      if (e.d || st) begin
        e.d = 1'b1;
        if (idx > e.dd) e.dd = idx;
      end
      stk[s].push_front(e);
    end else begin
      m_miss = sat(m_miss + 1);
      e.tg = t; e.d = st; e.dd = 0;
      stk[s].push_front(e);
      if (stk[s].size() > DEPTH) begin
        e = stk[s].pop_back();
        if (e.d) m_wb[e.dd] = sat(m_wb[e.dd] + 1);
      end
    end
  endtask

  // cycle reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) stk[s].delete();
      m_miss = 0;
      for (int i = 0; i < DEPTH; i++) begin m_hit[i] = 0; m_wb[i] = 0; end
      exp_miss = 0; exp_wb = 0;
    end else begin
      exp_miss = m_miss;
      exp_wb   = 0;
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(q_ways)) begin
          exp_miss = sat(exp_miss + m_hit[i]);
          exp_wb   = sat(exp_wb + m_wb[i]);
        end
      end
      if (acc_valid && acc_addr[10:6] == 5'd0)
        model_access(int'(acc_addr[12:11]), hfold(acc_addr[31:13]), acc_store);
      if (clr) begin
        m_miss = 0;
        for (int i = 0; i < DEPTH; i++) begin m_hit[i] = 0; m_wb[i] = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pred_miss !== exp_miss[CW-1:0] || pred_wb !== exp_wb[CW-1:0]) begin
        fails++;
        $display("FAIL %s model: miss=%0d exp=%0d wb=%0d exp=%0d",
                 phase, pred_miss, exp_miss, pred_wb, exp_wb);
      end
    end
  end

  task automatic expect2(input string req, input int em, input int ew);
    checks++;
    if (int'(pred_miss) != em || int'(pred_wb) != ew) begin
      fails++;
      $display("FAIL %s: miss=%0d exp=%0d wb=%0d exp=%0d", req, pred_miss, em, pred_wb, ew);
    end
  endtask

  task automatic acc(input logic [31:0] a, input bit st);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_store = st;
    @(negedge clk);
    acc_valid = 1'b0; acc_store = 1'b0;
  endtask

  task automatic qry(input int q);
    @(negedge clk);
    acc_valid = 1'b0; q_ways = 4'(q);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; acc_valid = 1'b0; acc_store = 1'b0;
    acc_addr = '0; q_ways = '0; phase = "R1"; checks = 0; fails = 0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect2("R1 reset", 0, 0);

    phase = "R2";
    acc(mk(0, 5) | (32'd1 << 6), 1'b1);
    acc(mk(1, 7) | (32'd3 << 6), 1'b0);
    acc(mk(2, 9) | (32'd16 << 6), 1'b1);
    @(negedge clk); acc_valid = 1'b0; acc_addr = mk(3, 1);
    qry(0);
    expect2("R2 unsampled ignored", 0, 0);

    phase = "R5";
    acc(mk(0, 1), 1'b0); acc(mk(0, 2), 1'b0); acc(mk(0, 3), 1'b0); acc(mk(0, 1), 1'b0);
    qry(0); expect2("R5 W=0", 4, 0);
    qry(3); expect2("R5 W=3", 3, 0);
    qry(2); expect2("R5 W=2", 4, 0);
    phase = "R4";
    acc(mk(0, 3), 1'b0);
    qry(1); expect2("R4 dist1 W=1", 5, 0);
    qry(2); expect2("R4 dist1 W=2", 4, 0);

    phase = "R10";
    pulse_clr();
    qry(0); expect2("R10 cleared", 0, 0);
    acc(mk(0, 2), 1'b0);
    qry(0); expect2("R10 stack kept W=0", 1, 0);
    qry(3); expect2("R10 stack kept W=3", 0, 0);

    phase = "R3";
    pulse_clr();
    acc(mk(1, 32'h1), 1'b0); acc(mk(1, 32'h800), 1'b0);
    qry(0); expect2("R3 alias W=0", 2, 0);
    qry(1); expect2("R3 alias W=1", 1, 0);
    acc(mk(1, 32'h2), 1'b0);
    qry(1); expect2("R3 distinct hash", 2, 0);

    phase = "R8";
    pulse_clr();
    acc(mk(2, 100), 1'b1);
    for (int k = 101; k <= 108; k++) acc(mk(2, k), 1'b0);
    qry(0); expect2("R8 no wb before drop", 9, 0);
    phase = "R6";
    acc(mk(2, 109), 1'b0);
    qry(0); expect2("R8 one wb at dist0", 10, 1);
    qry(1); expect2("R8 W=1 no wb", 10, 0);
    acc(mk(2, 100), 1'b0);
    qry(0); expect2("R6 dropped line misses", 11, 1);

    phase = "R7";
    pulse_clr();
    acc(mk(3, 1), 1'b1); acc(mk(3, 2), 1'b0); acc(mk(3, 3), 1'b0); acc(mk(3, 1), 1'b0);
    for (int k = 4; k <= 12; k++) acc(mk(3, k), 1'b0);
    qry(2); expect2("R7 max dist W=2", 13, 1);
    qry(3); expect2("R7 max dist W=3", 12, 0);

    phase = "R9";
    qry(15); expect2("R9 W above depth", 12, 0);
    @(negedge clk); q_ways = 4'd2;
    @(negedge clk); expect2("R9 one-cycle latency", 13, 1);

    phase = "R11";
    pulse_clr();
    for (int k = 0; k < 300; k++) acc(mk(0, 1000 + k), 1'b0);
    qry(0); expect2("R11 saturated", 255, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule